// File: doc/BRIEF.md
# Stride-Table Data Prefetcher

This block observes the stream of executed loads and stores, one access per cycle, each carrying the instruction address, the virtual data address and a flag that tells whether the access missed the L1. It keeps a direct-mapped table indexed by low instruction-address bits. In that table it learns which instructions step through memory with a fixed byte distance between their own consecutive accesses. Once an instruction has shown a stable stride, the block offers prefetch addresses one or more strides beyond the current access. It offers them on a valid/ready port toward the L1 request arbiter.

Each table entry is guarded by a two-bit confidence score. The score lets a well-behaved instruction keep its entry against occasional intruders. It also lets a stale entry be claimed by a new instruction once the score has drained to zero. Two further controls keep the request stream lean. A per-entry flag records that the instruction has recently missed, so that instructions which always hit do not flood the arbiter. A disable input, driven from a control-register bit, silences all requests while the table keeps learning.

A trace is registered on the clock edge after it is presented. During the following cycle the entry is read, updated and written back, and any prefetch for that trace is offered in that same cycle. An offer that is not accepted in that cycle is dropped.

Top module: `stride_prefetcher`

## Requirements
- R1: The entry index is trc_pc[PC_LSB+IDX_W-1:PC_LSB] and the tag is trc_pc[PC_W-1:PC_LSB+IDX_W]. An access owns the entry only when the entry is valid and its tag equals the access tag. Instruction-address bits below PC_LSB play no part.
- R2: An access that does not own its entry claims it when the entry is invalid or has score 0. The new entry holds the access tag and address, stride 0, score 1, advance 0 and missed equal to the access miss flag. A claim never produces a prefetch.
- R3: An access that does not own its entry, where the entry is valid with a score above 0, lowers that score by one and leaves every other field unchanged. It produces no prefetch.
- R4: For an owning access, the new stride is the access address minus the stored address, modulo 2^VA_W. If it equals the stored stride, the score rises by one and saturates at 3. Otherwise the score falls by one and saturates at 0, the stride is replaced by the new value and advance is cleared. In both cases the stored address becomes the access address.
- R5: On a same-stride access the missed flag becomes the old flag OR the access miss. On a stride break it becomes the access miss flag, so a miss in the same access that breaks the stride still sets it.
- R6: A prefetch is offered only for an owning same-stride access whose stride is non-zero and whose updated score is at least 2. Either the access missed or the old missed flag is set. The stored advance must also be below MAX_AHEAD and pf_off must be low.
- R7: The prefetch address is the access address plus (advance+1) times the stride, modulo 2^VA_W. pf_valid is high only in the cycle after the trace was presented, and only for that one cycle.
- R8: When pf_valid and pf_ready are both high, the entry's advance increases by one. An offer seen with pf_ready low is dropped, is never offered again, and leaves advance unchanged.
- R9: A same-stride owning access whose stored advance equals MAX_AHEAD produces no prefetch and lowers advance by one.
- R10: While pf_off is high no prefetch is offered, and the table updates exactly as it would with pf_off low, except that advance does not grow.
- R11: Accesses to the same entry in consecutive cycles are applied in order, each one seeing the entry as updated by the one before.
- R12: After reset every entry is invalid and pf_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trc_valid | input | 1 | An executed load or store is presented this cycle |
| trc_pc | input | PC_W | Instruction address of the access |
| trc_addr | input | VA_W | Virtual data address of the access |
| trc_miss | input | 1 | The access missed the L1 |
| pf_off | input | 1 | Disable bit from the control register |
| pf_valid | output | 1 | A prefetch address is offered |
| pf_addr | output | VA_W | Prefetch virtual address |
| pf_ready | input | 1 | The arbiter takes the offered prefetch this cycle |

## Verification
The bench goes after stride learning through the full score range, and the slow run-ahead that lets advance reach its cap and then back off. A design that did not back off at the cap would offer addresses that hit the cap again on every access. It drives strides that are negative or wrap the address space, and a stride of zero. A design that prefetched on a zero stride would request the same line over and over. It drives entries fought over by two instructions that share an index in back-to-back cycles. Here an off-by-one in the aging or claim rule moves the point at which ownership changes hands. It also exercises a miss that lands on the same access as a stride break. A design that let the clear win over the set would go silent on the following accesses. Refused offers, and offers made while disabled, must show up as unchanged advance in the addresses offered later. A design that replayed refused offers or counted them would drift ahead.

// File: rtl/spf_pkg.sv
package spf_pkg;
    localparam int SCORE_W = 2;
    typedef logic [SCORE_W-1:0] score_t;

    localparam score_t SCORE_TOP   = '1;
    localparam score_t SCORE_CLAIM = score_t'(1);
    localparam score_t SCORE_ISSUE = score_t'(2);

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_CLAIM,
        ACT_AGE,
        ACT_FOLLOW,
        ACT_BREAK
    } spf_act_e;

    function automatic score_t score_up(input score_t s);
        return (s == SCORE_TOP) ? s : s + score_t'(1);
    endfunction

    function automatic score_t score_down(input score_t s);
        return (s == '0) ? s : s - score_t'(1);
    endfunction
endpackage

// File: rtl/spf_trace_reg.sv
module spf_trace_reg #(
    parameter int PC_W = 32,
    parameter int VA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [PC_W-1:0] in_pc,
    input  logic [VA_W-1:0] in_addr,
    input  logic            in_miss,
    output logic            s_valid,
    output logic [PC_W-1:0] s_pc,
    output logic [VA_W-1:0] s_addr,
    output logic            s_miss
);
    typedef struct packed {
        logic            vld;
        logic [PC_W-1:0] pc;
        logic [VA_W-1:0] addr;
        logic            miss;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.pc   = in_pc;
            st_d.addr = in_addr;
            st_d.miss = in_miss;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign s_valid = st_q.vld;
    assign s_pc    = st_q.pc;
    assign s_addr  = st_q.addr;
    assign s_miss  = st_q.miss;
endmodule

// File: rtl/spf_table.sv
module spf_table
    import spf_pkg::*;
#(
    parameter int IDX_W     = 7,
    parameter int TAG_W     = 23,
    parameter int VA_W      = 32,
    parameter int MAX_AHEAD = 4,
    localparam int ADV_W    = $clog2(MAX_AHEAD + 1),
    localparam int DEPTH    = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_vld,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [VA_W-1:0]   rd_addr,
    output logic [VA_W-1:0]   rd_stride,
    output score_t            rd_score,
    output logic [ADV_W-1:0]  rd_adv,
    output logic              rd_missed,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_vld,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [VA_W-1:0]   wr_addr,
    input  logic [VA_W-1:0]   wr_stride,
    input  score_t            wr_score,
    input  logic [ADV_W-1:0]  wr_adv,
    input  logic              wr_missed
);
    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [VA_W-1:0]  addr;
        logic [VA_W-1:0]  stride;
        score_t           score;
        logic [ADV_W-1:0] adv;
        logic             missed;
    } entry_t;

    entry_t tbl_d [DEPTH];
    entry_t tbl_q [DEPTH];
    entry_t rd_ent;
    entry_t old_ent;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[wr_idx] = '{vld: wr_vld, tag: wr_tag, addr: wr_addr,
                              stride: wr_stride, score: wr_score,
                              adv: wr_adv, missed: wr_missed};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_ent    = tbl_q[rd_idx];
    assign rd_vld    = rd_ent.vld;
    assign rd_tag    = rd_ent.tag;
    assign rd_addr   = rd_ent.addr;
    assign rd_stride = rd_ent.stride;
    assign rd_score  = rd_ent.score;
    assign rd_adv    = rd_ent.adv;
    assign rd_missed = rd_ent.missed;

    // Entry being overwritten, for the ownership and score checks below.
    assign old_ent = tbl_q[wr_idx];

    AST_CLAIM_ONLY_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && old_ent.vld && (old_ent.tag != wr_tag)) |-> (old_ent.score == '0)); // R2

    AST_SCORE_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && old_ent.vld && (old_ent.tag == wr_tag)) |->
            ((int'(wr_score) == int'(old_ent.score) + 1) ||
             (int'(wr_score) + 1 == int'(old_ent.score)) ||
             ((wr_score == old_ent.score) &&
              ((old_ent.score == '0) || (old_ent.score == SCORE_TOP))))); // R4

    AST_ADV_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_adv) <= MAX_AHEAD)); // R9
endmodule

// File: rtl/spf_update.sv
module spf_update
    import spf_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int VA_W      = 32,
    parameter int IDX_W     = 7,
    parameter int PC_LSB    = 2,
    parameter int MAX_AHEAD = 4,
    localparam int TAG_W    = PC_W - IDX_W - PC_LSB,
    localparam int ADV_W    = $clog2(MAX_AHEAD + 1)
) (
    input  logic              s_valid,
    input  logic [PC_W-1:0]   s_pc,
    input  logic [VA_W-1:0]   s_addr,
    input  logic              s_miss,
    input  logic              pf_off,
    input  logic              pf_ready,
    output logic [IDX_W-1:0]  idx,
    input  logic              e_vld,
    input  logic [TAG_W-1:0]  e_tag,
    input  logic [VA_W-1:0]   e_addr,
    input  logic [VA_W-1:0]   e_stride,
    input  score_t            e_score,
    input  logic [ADV_W-1:0]  e_adv,
    input  logic              e_missed,
    output logic              wr_en,
    output logic              wr_vld,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [VA_W-1:0]   wr_addr,
    output logic [VA_W-1:0]   wr_stride,
    output score_t            wr_score,
    output logic [ADV_W-1:0]  wr_adv,
    output logic              wr_missed,
    output logic              pf_valid,
    output logic [VA_W-1:0]   pf_addr
);
    localparam logic [ADV_W-1:0] ADV_CAP = ADV_W'(MAX_AHEAD);

    typedef struct packed {
        spf_act_e         act;
        logic             en;
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [VA_W-1:0]  addr;
        logic [VA_W-1:0]  stride;
        score_t           score;
        logic [ADV_W-1:0] adv;
        logic             missed;
        logic             pf_v;
        logic [VA_W-1:0]  pf_a;
    } upd_t;

    upd_t             nx_d;
    logic [TAG_W-1:0] s_tag;
    logic [VA_W-1:0]  delta;
    logic [VA_W-1:0]  reach;
    logic             owned;
    logic             same;
    logic             wants;

    assign idx   = s_pc[PC_LSB +: IDX_W];
    assign s_tag = s_pc[PC_W-1 -: TAG_W];
    assign owned = e_vld && (e_tag == s_tag);
    assign delta = s_addr - e_addr;
    assign same  = (delta == e_stride);
    assign reach = VA_W'(e_adv) + VA_W'(1);

    always_comb begin
        nx_d        = '0;
        nx_d.act    = ACT_IDLE;
        nx_d.vld    = e_vld;
        nx_d.tag    = e_tag;
        nx_d.addr   = e_addr;
        nx_d.stride = e_stride;
        nx_d.score  = e_score;
        nx_d.adv    = e_adv;
        nx_d.missed = e_missed;
        wants       = 1'b0;

        if (s_valid) begin
            nx_d.en = 1'b1;
            if (!owned) begin
                nx_d.act = (!e_vld || (e_score == '0)) ? ACT_CLAIM : ACT_AGE;
            end else begin
                nx_d.act = same ? ACT_FOLLOW : ACT_BREAK;
            end
        end

        unique case (nx_d.act)
            ACT_CLAIM: begin
                nx_d.vld    = 1'b1;
                nx_d.tag    = s_tag;
                nx_d.addr   = s_addr;
                nx_d.stride = '0;
                nx_d.score  = SCORE_CLAIM;
                nx_d.adv    = '0;
                nx_d.missed = s_miss;
            end
            ACT_AGE: begin
                nx_d.score = score_down(e_score);
            end
            ACT_FOLLOW: begin
                nx_d.addr   = s_addr;
                nx_d.score  = score_up(e_score);
                nx_d.missed = e_missed | s_miss;
                wants = (nx_d.score >= SCORE_ISSUE) && (e_stride != '0) &&
                        (s_miss || e_missed);
                if (e_adv == ADV_CAP) begin
                    nx_d.adv = e_adv - ADV_W'(1);
                end else if (wants && !pf_off) begin
                    nx_d.pf_v = 1'b1;
                    nx_d.pf_a = s_addr + reach * e_stride;
                    if (pf_ready) begin
                        nx_d.adv = e_adv + ADV_W'(1);
                    end
                end
            end
            ACT_BREAK: begin
                nx_d.addr   = s_addr;
                nx_d.stride = delta;
                nx_d.score  = score_down(e_score);
                nx_d.adv    = '0;
                nx_d.missed = s_miss;
            end
            default: begin
                nx_d.en = 1'b0;
            end
        endcase
    end

    assign wr_en     = nx_d.en;
    assign wr_vld    = nx_d.vld;
    assign wr_tag    = nx_d.tag;
    assign wr_addr   = nx_d.addr;
    assign wr_stride = nx_d.stride;
    assign wr_score  = nx_d.score;
    assign wr_adv    = nx_d.adv;
    assign wr_missed = nx_d.missed;
    assign pf_valid  = nx_d.pf_v;
    assign pf_addr   = nx_d.pf_a;
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher
    import spf_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int VA_W      = 32,
    parameter int IDX_W     = 7,
    parameter int PC_LSB    = 2,
    parameter int MAX_AHEAD = 4,
    localparam int TAG_W    = PC_W - IDX_W - PC_LSB,
    localparam int ADV_W    = $clog2(MAX_AHEAD + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trc_valid,
    input  logic [PC_W-1:0] trc_pc,
    input  logic [VA_W-1:0] trc_addr,
    input  logic            trc_miss,
    input  logic            pf_off,
    output logic            pf_valid,
    output logic [VA_W-1:0] pf_addr,
    input  logic            pf_ready
);
    logic             s_valid;
    logic [PC_W-1:0]  s_pc;
    logic [VA_W-1:0]  s_addr;
    logic             s_miss;
    logic [IDX_W-1:0] idx;
    logic             e_vld;
    logic [TAG_W-1:0] e_tag;
    logic [VA_W-1:0]  e_addr;
    logic [VA_W-1:0]  e_stride;
    score_t           e_score;
    logic [ADV_W-1:0] e_adv;
    logic             e_missed;
    logic             wr_en;
    logic             wr_vld;
    logic [TAG_W-1:0] wr_tag;
    logic [VA_W-1:0]  wr_addr;
    logic [VA_W-1:0]  wr_stride;
    score_t           wr_score;
    logic [ADV_W-1:0] wr_adv;
    logic             wr_missed;

    spf_trace_reg #(.PC_W(PC_W), .VA_W(VA_W)) u_trace (
        .clk(clk), .rst_n(rst_n),
        .in_valid(trc_valid), .in_pc(trc_pc), .in_addr(trc_addr), .in_miss(trc_miss),
        .s_valid(s_valid), .s_pc(s_pc), .s_addr(s_addr), .s_miss(s_miss)
    );

    spf_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .VA_W(VA_W), .MAX_AHEAD(MAX_AHEAD)) u_table (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(idx),
        .rd_vld(e_vld), .rd_tag(e_tag), .rd_addr(e_addr), .rd_stride(e_stride),
        .rd_score(e_score), .rd_adv(e_adv), .rd_missed(e_missed),
        .wr_en(wr_en), .wr_idx(idx),
        .wr_vld(wr_vld), .wr_tag(wr_tag), .wr_addr(wr_addr), .wr_stride(wr_stride),
        .wr_score(wr_score), .wr_adv(wr_adv), .wr_missed(wr_missed)
    );

    spf_update #(.PC_W(PC_W), .VA_W(VA_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB),
                 .MAX_AHEAD(MAX_AHEAD)) u_update (
        .s_valid(s_valid), .s_pc(s_pc), .s_addr(s_addr), .s_miss(s_miss),
        .pf_off(pf_off), .pf_ready(pf_ready),
        .idx(idx),
        .e_vld(e_vld), .e_tag(e_tag), .e_addr(e_addr), .e_stride(e_stride),
        .e_score(e_score), .e_adv(e_adv), .e_missed(e_missed),
        .wr_en(wr_en), .wr_vld(wr_vld), .wr_tag(wr_tag), .wr_addr(wr_addr),
        .wr_stride(wr_stride), .wr_score(wr_score), .wr_adv(wr_adv),
        .wr_missed(wr_missed),
        .pf_valid(pf_valid), .pf_addr(pf_addr)
    );

    // Instruction-address bits below the index are not used by the table.
    generate
        if (PC_LSB > 0) begin : g_pc_lo
            logic unused_pc_lo;
            assign unused_pc_lo = ^s_pc[PC_LSB-1:0];
        end
    endgenerate

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> !pf_off); // R10

    AST_OFFER_FOLLOWS_TRACE: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> $past(trc_valid)); // R7

    AST_OFFER_NEEDS_CONFIDENCE: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (wr_score >= SCORE_ISSUE) && (e_stride != '0)); // R6
endmodule

// File: tb/sim_stride_prefetcher.sv
`timescale 1ns/1ps
module sim_stride_prefetcher;
    localparam int PC_W   = 16;
    localparam int VA_W   = 16;
    localparam int IDX_W  = 4;
    localparam int PC_LSB = 2;
    localparam int MAXA   = 3;
    localparam int SETS   = 1 << IDX_W;
    localparam int TAG_W  = PC_W - IDX_W - PC_LSB;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trc_valid = 1'b0;
    logic [PC_W-1:0] trc_pc = '0;
    logic [VA_W-1:0] trc_addr = '0;
    logic            trc_miss = 1'b0;
    logic            pf_off = 1'b0;
    logic            pf_ready = 1'b0;
    logic            pf_valid;
    logic [VA_W-1:0] pf_addr;

    always #10 clk = ~clk;

    stride_prefetcher #(.PC_W(PC_W), .VA_W(VA_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB),
                        .MAX_AHEAD(MAXA)) u0 (
        .clk(clk), .rst_n(rst_n), .trc_valid(trc_valid), .trc_pc(trc_pc),
        .trc_addr(trc_addr), .trc_miss(trc_miss), .pf_off(pf_off),
        .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_ready(pf_ready)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Expected table contents, built from the requirements.
    bit              m_v   [SETS];
    logic [TAG_W-1:0] m_tag [SETS];
    logic [VA_W-1:0] m_addr[SETS];
    logic [VA_W-1:0] m_str [SETS];
    int              m_sc  [SETS];
    int              m_adv [SETS];
    bit              m_ms  [SETS];

    // The trace whose result is visible in the next cycle.
    bit              p_val = 1'b0;
    logic [PC_W-1:0] p_pc = '0;
    logic [VA_W-1:0] p_addr = '0;
    bit              p_miss = 1'b0;
    bit              p_rdy = 1'b0;
    bit              p_off = 1'b0;
    string           p_req = "R12";

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic eval_pending();
        int i;
        logic [TAG_W-1:0] t;
        logic [VA_W-1:0] d;
        logic [VA_W-1:0] ea;
        bit ev;
        int ns;
        ev = 1'b0;
        ea = '0;
        if (p_val) begin
            i = int'(p_pc[PC_LSB +: IDX_W]);
            t = p_pc[PC_W-1 -: TAG_W];
            if (!(m_v[i] && m_tag[i] == t)) begin
                if (!m_v[i] || m_sc[i] == 0) begin
                    m_v[i] = 1'b1; m_tag[i] = t; m_addr[i] = p_addr; m_str[i] = '0;
                    m_sc[i] = 1; m_adv[i] = 0; m_ms[i] = p_miss;
                end else begin
                    m_sc[i] = m_sc[i] - 1;
                end
            end else begin
                d = p_addr - m_addr[i];
                if (d == m_str[i]) begin
                    ns = (m_sc[i] == 3) ? 3 : m_sc[i] + 1;
                    if (m_adv[i] == MAXA) begin
                        m_adv[i] = m_adv[i] - 1;
                    end else if (ns >= 2 && m_str[i] != '0 && (p_miss || m_ms[i]) && !p_off) begin
                        ev = 1'b1;
                        ea = p_addr + VA_W'(m_adv[i] + 1) * m_str[i];
                        if (p_rdy) m_adv[i] = m_adv[i] + 1;
                    end
                    m_sc[i] = ns;
                    m_ms[i] = m_ms[i] | p_miss;
                end else begin
                    m_str[i] = d;
                    m_sc[i] = (m_sc[i] == 0) ? 0 : m_sc[i] - 1;
                    m_adv[i] = 0;
                    m_ms[i] = p_miss;
                end
                m_addr[i] = p_addr;
            end
        end
        chk(pf_valid === ev, p_req, "pf_valid", int'(pf_valid), int'(ev));
        if (ev) chk(pf_addr === ea, p_req, "pf_addr", int'(pf_addr), int'(ea));
    endtask

    task automatic acc(input logic [PC_W-1:0] pc, input logic [VA_W-1:0] a,
                       input bit miss, input bit rdy, input bit off, input string req);
        @(negedge clk);
        pf_ready = p_rdy;
        pf_off = p_off;
        #1;
        eval_pending();
        trc_valid = 1'b1; trc_pc = pc; trc_addr = a; trc_miss = miss;
        p_val = 1'b1; p_pc = pc; p_addr = a; p_miss = miss;
        p_rdy = rdy; p_off = off; p_req = req;
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        pf_ready = p_rdy;
        pf_off = p_off;
        #1;
        eval_pending();
        trc_valid = 1'b0; trc_miss = 1'b0;
        p_val = 1'b0; p_rdy = 1'b1; p_off = 1'b0; p_req = req;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < SETS; i++) begin
            m_v[i] = 1'b0; m_tag[i] = '0; m_addr[i] = '0; m_str[i] = '0;
            m_sc[i] = 0; m_adv[i] = 0; m_ms[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(pf_valid === 1'b0, "R12", "pf_valid after reset", int'(pf_valid), 0);

        // Steady stream: score climbs, advance runs to the cap and backs off.
        for (int k = 0; k < 14; k++)
            acc(16'h0104, 16'h2000 + 16'(k * 64), 1'b1, 1'b1, 1'b0, "R4/R6/R9");

        // Every set, alternating signs, wrapping addresses, mixed misses.
        for (int s = 0; s < SETS; s++) begin
            logic [VA_W-1:0] st;
            logic [PC_W-1:0] pc;
            st = (s % 2 == 1) ? -16'((s + 1) * 4) : 16'((s + 1) * 12);
            pc = PC_W'((s + 3) << (IDX_W + PC_LSB)) | PC_W'(s << PC_LSB);
            for (int k = 0; k < 9; k++)
                acc(pc, 16'hF000 + 16'(k) * st, (k % 3) == 0, 1'b1, 1'b0, "R1/R7");
        end

        // Refused offers are dropped and do not move advance.
        for (int k = 0; k < 12; k++)
            acc(16'h0208, 16'h4000 + 16'(k * 32), 1'b1, (k % 2) == 1, 1'b0, "R8");

        // Missed filter: hits stay quiet, one miss re-arms, set beats clear.
        for (int k = 0; k < 8; k++)
            acc(16'h030C, 16'h5000 + 16'(k * 16), 1'b0, 1'b1, 1'b0, "R5");
        acc(16'h030C, 16'h5080, 1'b1, 1'b1, 1'b0, "R5");
        for (int k = 1; k < 5; k++)
            acc(16'h030C, 16'h5080 + 16'(k * 16), 1'b0, 1'b1, 1'b0, "R5");
        acc(16'h030C, 16'h6000, 1'b1, 1'b1, 1'b0, "R5");
        for (int k = 1; k < 5; k++)
            acc(16'h030C, 16'h6000 + 16'(k * 16), 1'b0, 1'b1, 1'b0, "R5");
        acc(16'h030C, 16'h7000, 1'b0, 1'b1, 1'b0, "R5");
        for (int k = 1; k < 5; k++)
            acc(16'h030C, 16'h7000 + 16'(k * 16), 1'b0, 1'b1, 1'b0, "R5");

        // Disable: silence with learning continuing.
        for (int k = 0; k < 15; k++)
            acc(16'h0410, 16'h8000 + 16'(k * 8), 1'b1, 1'b1, (k >= 6 && k < 11), "R10");

        // Ownership contest on one set.
        for (int k = 0; k < 8; k++)
            acc(16'h0514, 16'h9000 + 16'(k * 4), 1'b1, 1'b1, 1'b0, "R2/R3");
        for (int k = 0; k < 6; k++)
            acc(16'h0554, 16'hA000 + 16'(k * 4), 1'b1, 1'b1, 1'b0, "R2/R3");
        for (int k = 0; k < 4; k++)
            acc(16'h0514, 16'h9020 + 16'(k * 4), 1'b1, 1'b1, 1'b0, "R2");

        // Two instructions on one set in back-to-back cycles.
        for (int k = 0; k < 10; k++)
            acc((k % 2 == 0) ? 16'h0618 : 16'h0658, 16'hB000 + 16'(k * 8),
                1'b1, 1'b1, 1'b0, "R11");

        // Address bits below the index share one owner.
        for (int k = 0; k < 8; k++)
            acc((k % 2 == 0) ? 16'h0720 : 16'h0723, 16'hC000 + 16'(k * 16),
                1'b1, 1'b1, 1'b0, "R1");

        // Zero stride never prefetches.
        for (int k = 0; k < 6; k++)
            acc(16'h0824, 16'hD000, 1'b1, 1'b1, 1'b0, "R6");

        idle("R7");
        idle("R7");
        idle("R7");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule